// File: doc/BRIEF.md
# Planar Adaptive Route Selector

This block takes the per-hop output-port decision for a router in a three-dimensional mesh. Routing is confined to two-dimensional planes that are visited in a fixed order: plane 0 spans X and Y, and plane 1 spans Y and Z. Inside the active plane the selector chooses between the productive directions of the two dimensions. It uses a per-port busy mask, so traffic can steer around congested or broken links. A packet leaves plane 0 only after its X offset has reached zero. It never routes in plane 0 again.

A request presents the current and destination coordinates together with the plane index the packet carries. The selector answers with the chosen port, the plane index the packet should carry onward, and the virtual-channel class for that plane. When no candidate port is free, the request is held inside the block. `req_ready` drops and the decision is re-evaluated against the live busy mask on every cycle until a candidate becomes free.

Top module: `planar_route_sel`

## Requirements
- R1: While reset is high, and in the first cycle after it, `rsp_valid` is 0 and `req_ready` is 1.
- R2: Port codes are 0 = local, 1 = +X, 2 = -X, 3 = +Y, 4 = -Y, 5 = +Z, 6 = -Z. Bit k of `port_busy` marks port code k as busy. The plus direction of a dimension is chosen when the destination coordinate exceeds the current one, and the minus direction when it is lower.
- R3: In plane 0 with both X and Y offsets non-zero and both productive ports free, the dimension with the larger absolute offset is taken. On equal offsets X is taken.
- R4: When only one of the two productive ports in the active plane is free, that port is taken.
- R5: When no candidate is free, no response is given and `req_ready` stays 0. The coordinates captured at acceptance are used, and the response appears one cycle after the edge at which a candidate is seen free.
- R6: A plane-0 request whose X offset is zero is routed in plane 1 among the Y and Z directions and reports plane 1.
- R7: A request that already carries plane 1 stays in plane 1, and its X offset has no effect.
- R8: When the Y and Z offsets are both zero in plane 1, the local port is selected. If the local port is busy, the request is held as in R5.
- R9: `rsp_vc` equals the reported plane index.
- R10: A request accepted while a candidate is free is answered one cycle after acceptance.
- R11: Busy bits of ports that are not candidates for the request do not change the choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| cur_x | input | CW | Current X coordinate |
| cur_y | input | CW | Current Y coordinate |
| cur_z | input | CW | Current Z coordinate |
| dst_x | input | CW | Destination X coordinate |
| dst_y | input | CW | Destination Y coordinate |
| dst_z | input | CW | Destination Z coordinate |
| plane_in | input | 1 | Plane index carried by the packet |
| port_busy | input | 7 | Busy or faulty flag per output port code |
| rsp_valid | output | 1 | Decision valid for one cycle |
| rsp_port | output | 3 | Chosen output port code |
| rsp_plane | output | 1 | Plane index to carry onward |
| rsp_vc | output | VC_W | Virtual-channel class |

## Verification
A decision for a request accepted with a free candidate is registered at the accepting edge. The bench therefore expects it at the falling edge that follows and confirms that the scoreboard is empty just after it. For held requests, the bench samples at each falling edge during the hold and checks that `req_ready` is low and the expected item is still queued. It then frees a port between edges and expects the item to be popped at the very next falling edge. The coordinate inputs are scrambled after acceptance, so a correct answer shows that the stored values were used.

// File: rtl/route_pkg.sv
package route_pkg;
  localparam int NUM_DIMS   = 3;
  localparam int NUM_PLANES = NUM_DIMS - 1;
  localparam int PW         = (NUM_PLANES > 1) ? $clog2(NUM_PLANES) : 1;
  localparam int NUM_PORTS  = 2 * NUM_DIMS + 1;
  localparam int DW         = $clog2(NUM_DIMS);

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_XP    = 3'd1,
    PORT_XN    = 3'd2,
    PORT_YP    = 3'd3,
    PORT_YN    = 3'd4,
    PORT_ZP    = 3'd5,
    PORT_ZN    = 3'd6
  } port_e;
endpackage

// File: rtl/route_axis_offset.sv
module route_axis_offset
  import route_pkg::*;
#(
  parameter int CW  = 3,
  parameter int DIM = 0
) (
  input  logic [CW-1:0] cur,
  input  logic [CW-1:0] dst,
  output logic [CW-1:0] mag,
  output logic          active,
  output port_e         dir
);
  localparam port_e PLUS_PORT  = port_e'(3'(1 + 2 * DIM));
  localparam port_e MINUS_PORT = port_e'(3'(2 + 2 * DIM));

  always_comb begin
    if (dst >= cur) begin
      mag = dst - cur;
      dir = PLUS_PORT;
    end else begin
      mag = cur - dst;
      dir = MINUS_PORT;
    end
    active = (mag != '0);
  end
endmodule

// File: rtl/route_plane_ctrl.sv
module route_plane_ctrl
  import route_pkg::*;
(
  input  logic [PW-1:0] plane_src,
  input  logic          lead_done,
  output logic [PW-1:0] plane_eff,
  output logic [DW-1:0] dim_lo,
  output logic [DW-1:0] dim_hi,
  output logic          last_plane
);
  // plane p covers dimensions p and p+1; leave only when dim p is resolved
  always_comb begin
    if (lead_done && (int'(plane_src) < NUM_PLANES - 1))
      plane_eff = plane_src + PW'(1);
    else
      plane_eff = plane_src;
    dim_lo     = DW'(plane_eff);
    dim_hi     = DW'(plane_eff) + DW'(1);
    last_plane = (int'(plane_eff) == NUM_PLANES - 1);
  end
endmodule

// File: rtl/route_port_pick.sv
module route_port_pick
  import route_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic                 lo_act,
  input  logic [CW-1:0]        lo_mag,
  input  port_e                lo_port,
  input  logic                 hi_act,
  input  logic [CW-1:0]        hi_mag,
  input  port_e                hi_port,
  input  logic                 eject,
  input  logic [NUM_PORTS-1:0] busy,
  output logic                 grant,
  output port_e                port
);
  logic lo_free, hi_free;

  always_comb begin
    lo_free = lo_act && !busy[lo_port];
    hi_free = hi_act && !busy[hi_port];
    grant   = 1'b0;
    port    = PORT_LOCAL;
    if (eject) begin
      grant = !busy[PORT_LOCAL];
    end else if (lo_free && hi_free) begin
      grant = 1'b1;
      port  = (hi_mag > lo_mag) ? hi_port : lo_port;
    end else if (lo_free) begin
      grant = 1'b1;
      port  = lo_port;
    end else if (hi_free) begin
      grant = 1'b1;
      port  = hi_port;
    end
  end
endmodule

// File: rtl/planar_route_sel.sv
module planar_route_sel
  import route_pkg::*;
#(
  parameter int CW   = 3,
  parameter int VC_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [CW-1:0]        cur_x,
  input  logic [CW-1:0]        cur_y,
  input  logic [CW-1:0]        cur_z,
  input  logic [CW-1:0]        dst_x,
  input  logic [CW-1:0]        dst_y,
  input  logic [CW-1:0]        dst_z,
  input  logic [PW-1:0]        plane_in,
  input  logic [NUM_PORTS-1:0] port_busy,
  output logic                 rsp_valid,
  output logic [2:0]           rsp_port,
  output logic [PW-1:0]        rsp_plane,
  output logic [VC_W-1:0]      rsp_vc
);
  logic                          pend_q;
  logic [NUM_DIMS-1:0][CW-1:0]   cur_q, dst_q;
  logic [PW-1:0]                 plane_q;

  logic [NUM_DIMS-1:0][CW-1:0]   cur_in, dst_in, cur_sel, dst_sel, mag;
  logic [NUM_DIMS-1:0]           act;
  port_e                         dir [NUM_DIMS];
  logic [PW-1:0]                 plane_sel, plane_eff;
  logic [DW-1:0]                 dim_lo, dim_hi;
  logic                          last_plane, eject, grant, eval;
  port_e                         pick;

  assign cur_in    = {cur_z, cur_y, cur_x};
  assign dst_in    = {dst_z, dst_y, dst_x};
  assign cur_sel   = pend_q ? cur_q : cur_in;
  assign dst_sel   = pend_q ? dst_q : dst_in;
  assign plane_sel = pend_q ? plane_q : plane_in;
  assign eval      = pend_q || req_valid;
  assign req_ready = !pend_q;

  for (genvar g = 0; g < NUM_DIMS; g++) begin : g_axis
    route_axis_offset #(.CW(CW), .DIM(g)) u_axis (
      .cur    (cur_sel[g]),
      .dst    (dst_sel[g]),
      .mag    (mag[g]),
      .active (act[g]),
      .dir    (dir[g])
    );
  end

  route_plane_ctrl u_plane (
    .plane_src  (plane_sel),
    .lead_done  (!act[DW'(plane_sel)]),
    .plane_eff  (plane_eff),
    .dim_lo     (dim_lo),
    .dim_hi     (dim_hi),
    .last_plane (last_plane)
  );

  assign eject = last_plane && !act[dim_lo] && !act[dim_hi];

  route_port_pick #(.CW(CW)) u_pick (
    .lo_act  (act[dim_lo]),
    .lo_mag  (mag[dim_lo]),
    .lo_port (dir[dim_lo]),
    .hi_act  (act[dim_hi]),
    .hi_mag  (mag[dim_hi]),
    .hi_port (dir[dim_hi]),
    .eject   (eject),
    .busy    (port_busy),
    .grant   (grant),
    .port    (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      cur_q     <= '0;
      dst_q     <= '0;
      plane_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_port  <= '0;
      rsp_plane <= '0;
      rsp_vc    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (!pend_q) begin
        cur_q   <= cur_in;
        dst_q   <= dst_in;
        plane_q <= plane_in;
      end
      if (eval && grant) begin
        rsp_valid <= 1'b1;
        rsp_port  <= pick;
        rsp_plane <= plane_eff;
        rsp_vc    <= VC_W'(plane_eff);
        pend_q    <= 1'b0;
      end else if (eval) begin
        pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/route_sel_chk.sv
module route_sel_chk
  import route_pkg::*;
#(
  parameter int VC_W = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_ready,
  input logic [NUM_PORTS-1:0] port_busy,
  input logic                 rsp_valid,
  input logic [2:0]           rsp_port,
  input logic [PW-1:0]        rsp_plane,
  input logic [VC_W-1:0]      rsp_vc
);
  logic [NUM_PORTS-1:0] busy_q;

  always_ff @(posedge clk) begin
    if (rst) busy_q <= '1;
    else     busy_q <= port_busy;
  end

  assert_port_code_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_port <= 3'd6));

  assert_free_port_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !busy_q[rsp_port]);

  assert_plane0_dirs_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_plane == '0) |-> (rsp_port >= 3'd1 && rsp_port <= 3'd4));

  assert_plane1_dirs_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_plane != '0) |-> (rsp_port == 3'd0 || rsp_port >= 3'd3));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> (rsp_valid || !req_ready));

  assert_vc_class_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_vc == VC_W'(rsp_plane)));
endmodule

bind planar_route_sel route_sel_chk #(.VC_W(VC_W)) u_route_sel_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .port_busy (port_busy),
  .rsp_valid (rsp_valid),
  .rsp_port  (rsp_port),
  .rsp_plane (rsp_plane),
  .rsp_vc    (rsp_vc)
);

// File: tb/test_planar_route_sel.sv
module test_planar_route_sel;
  localparam int CW = 3;
  localparam int VC_W = 2;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_ready;
  logic [CW-1:0] cur_x = 0, cur_y = 0, cur_z = 0, dst_x = 0, dst_y = 0, dst_z = 0;
  logic [0:0] plane_in = 0;
  logic [6:0] port_busy = 0;
  logic rsp_valid;
  logic [2:0] rsp_port;
  logic [0:0] rsp_plane;
  logic [VC_W-1:0] rsp_vc;

  int checks = 0, errors = 0;
  logic [3:0] exp_q [$];
  string tag_q [$];
  bit finished = 0;

  always #5 clk = ~clk;

  planar_route_sel #(.CW(CW), .VC_W(VC_W)) i_planar_route_sel (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .cur_x(cur_x), .cur_y(cur_y), .cur_z(cur_z),
    .dst_x(dst_x), .dst_y(dst_y), .dst_z(dst_z),
    .plane_in(plane_in), .port_busy(port_busy),
    .rsp_valid(rsp_valid), .rsp_port(rsp_port), .rsp_plane(rsp_plane), .rsp_vc(rsp_vc)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a decision appears
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "unexpected response", rsp_port, -1);
      end else begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_port == e[3:1], {t, " port"}, rsp_port, e[3:1]);
        chk(rsp_plane == e[0], {t, " plane"}, rsp_plane, e[0]);
        chk(rsp_vc == VC_W'(e[0]), "R9 vc class", rsp_vc, e[0]);
      end
    end
  end

  // driver: one request; hold>0 means every candidate is busy for hold cycles
  task automatic send(input int cx, cy, cz, dx, dy, dz, input int pl,
                      input logic [6:0] busy, input int ep, epl,
                      input int hold, input logic [6:0] busy_after, input string tag);
    @(negedge clk);
    cur_x = CW'(cx); cur_y = CW'(cy); cur_z = CW'(cz);
    dst_x = CW'(dx); dst_y = CW'(dy); dst_z = CW'(dz);
    plane_in = 1'(pl); port_busy = busy; req_valid = 1;
    exp_q.push_back({3'(ep), 1'(epl)});
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 0;
    cur_x = 7; cur_y = 0; cur_z = 7; dst_x = 0; dst_y = 7; dst_z = 0; plane_in = 0;
    if (hold == 0) begin
      #1 chk(exp_q.size() == 0, "R10 one-cycle answer", exp_q.size(), 0);
    end else begin
      for (int i = 0; i < hold; i++) begin
        if (i > 0) @(negedge clk);
        #1 chk(!req_ready && exp_q.size() == 1, "R5 held", exp_q.size(), 1);
      end
      port_busy = busy_after;
      @(negedge clk);
      #1 chk(exp_q.size() == 0 && req_ready, "R5 released", exp_q.size(), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!rsp_valid && req_ready, "R1 in reset", rsp_valid, 0);
    rst = 0;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R1 after reset", rsp_valid, 0);

    send(1,1,1, 4,2,1, 0, 7'h00, 1, 0, 0, 7'h00, "R3 larger X");
    send(5,1,0, 2,6,0, 0, 7'h00, 3, 0, 0, 7'h00, "R3 larger Y");
    send(2,2,0, 4,0,0, 0, 7'h00, 1, 0, 0, 7'h00, "R3 tie to X");
    send(6,6,0, 3,3,0, 0, 7'h00, 2, 0, 0, 7'h00, "R2 minus X");
    send(1,1,0, 4,2,0, 0, 7'h02, 3, 0, 0, 7'h00, "R4 X busy");
    send(3,5,0, 6,1,0, 0, 7'h10, 1, 0, 0, 7'h00, "R4 Y busy");
    send(3,1,1, 3,4,6, 0, 7'h00, 5, 1, 0, 7'h00, "R6 advance");
    send(3,5,4, 3,3,3, 0, 7'h00, 4, 1, 0, 7'h00, "R6 plane1 Y");
    send(0,2,2, 7,2,0, 1, 7'h00, 6, 1, 0, 7'h00, "R7 X ignored");
    send(5,3,3, 0,3,3, 1, 7'h00, 0, 1, 0, 7'h00, "R7 eject in plane1");
    send(4,4,4, 4,4,4, 0, 7'h00, 0, 1, 0, 7'h00, "R8 eject");
    send(1,1,1, 4,2,1, 0, 7'h65, 1, 0, 0, 7'h00, "R11 other busy");
    send(1,1,0, 4,2,0, 0, 7'h0A, 1, 0, 3, 7'h08, "R5 hold then X");
    send(2,2,2, 2,2,2, 0, 7'h01, 0, 1, 2, 7'h7E, "R8 local busy");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule